// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block caches translations from virtual page numbers to physical page numbers in front of a page-table walker. Every request carries a virtual address and an access type. The virtual page number is compared against every valid entry at the same time. On a hit, the block answers combinationally in the acceptance cycle. The answer is either a physical address, formed from the cached page number and the untouched 12-bit page offset, or a permission fault. The fault comes from the read, write and execute bits stored with the entry.

On a miss, the block stops accepting requests and raises a walk request toward the walker. It holds that request until the walker answers. A good answer is returned to the requester in the same cycle. It is also written into a free entry, or else into the least recently used one. A faulting walk is passed back to the requester and installs nothing. A flush input drops every translation in one cycle, for use at context switches.

Top module: `tlb_fa`

## Requirements
- R1: After reset, no entry is valid. `req_ready` is 1, and both `rsp_valid` and `walk_req_valid` are 0.
- R2: An accepted request (`req_valid && req_ready`) whose page number matches a valid entry returns `rsp_valid` in the same cycle. The response carries `rsp_paddr = {cached page number, req_vaddr[11:0]}` and no walk is issued.
- R3: On a hit, the access type is checked against the cached permission bits. `req_acc` is 0 for load (needs bit 0, read), 1 for store (needs bit 1, write), 2 for fetch (needs bit 2, execute), and 3 is treated as a load. A violation answers with `rsp_fault = 1` in the same cycle and issues no walk.
- R4: An accepted request that misses raises `walk_req_valid` in the next cycle, with `walk_req_vpn` equal to the request's page number. Both are held stable, and `req_ready` stays 0, until the cycle in which `walk_rsp_valid` is seen.
- R5: A walk answer with `walk_rsp_fault = 1` produces `rsp_valid` with `rsp_fault = 1` in that same cycle and installs nothing, so the next access to that page walks again.
- R6: A walk answer without fault produces, in that same cycle, `rsp_paddr = {walk_rsp_ppn, offset}`. The fault is computed from `walk_rsp_perm` under the R3 encoding. The translation is installed so that later accesses to the page hit.
- R7: A one-cycle `flush` pulse invalidates every entry, and `req_ready` is 0 during the flush cycle.
- R8: A fill takes an invalid entry whenever one exists, so as many distinct pages as there are entries all stay resident.
- R9: When all entries are valid, a fill replaces the least recently used entry. Every hit, with or without a permission fault, and every fill makes its entry the most recently used.
- R10: If `flush` is seen while a walk is outstanding, the walk answer is still returned to the requester but is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all translations |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_vaddr | input | VPN_W+12 | Virtual address of the request |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 load |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_paddr | output | PPN_W+12 | Physical address (meaningful when no fault) |
| rsp_fault | output | 1 | Permission or walk fault |
| walk_req_valid | output | 1 | Walk requested |
| walk_req_vpn | output | VPN_W | Page number to walk |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_ppn | input | PPN_W | Physical page number from the walker |
| walk_rsp_perm | input | 3 | Permission bits {execute, write, read} |
| walk_rsp_fault | input | 1 | Walker found no valid mapping |

## Verification
A hit is due in the same cycle it is accepted, and a miss shows its walk request one clock after acceptance. The answer to a miss comes in the cycle the walker replies, which the bench walker sets to two clocks after it first sees the request. The bench drives inputs just after a rising edge and samples outputs at the falling edge. Each response is therefore compared in the very cycle it is due. The scoreboard also records whether a walk happened since the previous response, which separates hits from fills. Recency is tested by filling every entry, touching them in a known order, and predicting which pages must walk again.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int PAGE_OFF_W = 12;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } tlb_state_e;

    function automatic logic perm_ok(input perm_t p, input acc_e a);
        case (a)
            ACC_STORE: perm_ok = p.w;
            ACC_FETCH: perm_ok = p.x;
            default:   perm_ok = p.r;
        endcase
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lookup_vpn,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  perm_t              fill_perm,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [PPN_W-1:0]   hit_ppn,
    output perm_t              hit_perm,
    output logic [ENTRIES-1:0] valid_vec
);

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        perm_t            perm;
    } slot_t;

    slot_t              slot_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match_vec;

    // One comparator per entry, all active at once
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid_q[g] && (slot_q[g].vpn == lookup_vpn);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            slot_q[fill_idx] <= '{vpn: fill_vpn, ppn: fill_ppn, perm: fill_perm};
        end
    end

    // Tags are unique, so the match vector is one-hot: OR-encode it
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                hit_idx = hit_idx | IDX_W'(i);
            end
        end
    end

    assign hit       = |match_vec;
    assign hit_ppn   = slot_q[hit_idx].ppn;
    assign hit_perm  = slot_q[hit_idx].perm;
    assign valid_vec = valid_q;

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim_idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    // Ages form a permutation of 0..ENTRIES-1; 0 is most recent
    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [IDX_W-1:0] touched_age;

    assign touched_age = age_q[touch_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                age_q[i] <= IDX_W'(i);
            end
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    age_q[i] <= '0;
                end else if (age_q[i] < touched_age) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        logic found_free;
        found_free = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found_free && !valid_vec[i]) begin
                victim_idx = IDX_W'(i);
                found_free = 1'b1;
            end
        end
        if (!found_free) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_q[i] == OLDEST) begin
                    victim_idx = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int IDX_W = 6,
    localparam int PA_W = PPN_W + PAGE_OFF_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  req_valid,
    input  logic [VPN_W-1:0]      req_vpn,
    input  logic [PAGE_OFF_W-1:0] req_off,
    input  acc_e                  req_acc,
    output logic                  req_ready,
    input  logic                  hit,
    input  logic [IDX_W-1:0]      hit_idx,
    input  logic [PPN_W-1:0]      hit_ppn,
    input  perm_t                 hit_perm,
    input  logic [IDX_W-1:0]      victim_idx,
    output logic                  rsp_valid,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  rsp_fault,
    output logic                  walk_req_valid,
    output logic [VPN_W-1:0]      walk_req_vpn,
    input  logic                  walk_rsp_valid,
    input  logic [PPN_W-1:0]      walk_rsp_ppn,
    input  perm_t                 walk_rsp_perm,
    input  logic                  walk_rsp_fault,
    output logic                  fill_en,
    output logic [IDX_W-1:0]      fill_idx,
    output logic [VPN_W-1:0]      fill_vpn,
    output logic                  touch_en,
    output logic [IDX_W-1:0]      touch_idx
);

    tlb_state_e            state_q;
    logic [VPN_W-1:0]      vpn_q;
    logic [PAGE_OFF_W-1:0] off_q;
    acc_e                  acc_q;
    logic                  drop_q;
    logic                  accept;
    logic                  walk_done;

    always_comb begin
        req_ready = (state_q == ST_IDLE) && !flush;
        accept    = req_valid && req_ready;
        walk_done = (state_q == ST_WALK) && walk_rsp_valid;

        rsp_valid = (accept && hit) || walk_done;
        if (walk_done) begin
            rsp_paddr = {walk_rsp_ppn, off_q};
            rsp_fault = walk_rsp_fault || !perm_ok(walk_rsp_perm, acc_q);
        end else begin
            rsp_paddr = {hit_ppn, req_off};
            rsp_fault = !perm_ok(hit_perm, req_acc);
        end

        walk_req_valid = (state_q == ST_WALK);
        walk_req_vpn   = vpn_q;

        fill_en   = walk_done && !walk_rsp_fault && !drop_q && !flush;
        fill_idx  = victim_idx;
        fill_vpn  = vpn_q;
        touch_en  = (accept && hit) || fill_en;
        touch_idx = fill_en ? victim_idx : hit_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vpn_q   <= '0;
            off_q   <= '0;
            acc_q   <= ACC_LOAD;
            drop_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept && !hit) begin
                        state_q <= ST_WALK;
                        vpn_q   <= req_vpn;
                        off_q   <= req_off;
                        acc_q   <= req_acc;
                        drop_q  <= 1'b0;
                    end
                end
                default: begin
                    if (flush) begin
                        drop_q <= 1'b1;
                    end
                    if (walk_rsp_valid) begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VA_W   = VPN_W + PAGE_OFF_W,
    localparam int PA_W   = PPN_W + PAGE_OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_req_vpn,
    input  logic             walk_rsp_valid,
    input  logic [PPN_W-1:0] walk_rsp_ppn,
    input  logic [2:0]       walk_rsp_perm,
    input  logic             walk_rsp_fault
);

    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [PPN_W-1:0]   hit_ppn;
    perm_t              hit_perm;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   victim_idx;
    logic               fill_en;
    logic [IDX_W-1:0]   fill_idx;
    logic [VPN_W-1:0]   fill_vpn;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;

    tlb_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .IDX_W   (IDX_W)
    ) u_cam (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .lookup_vpn (req_vaddr[VA_W-1:PAGE_OFF_W]),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .fill_vpn   (fill_vpn),
        .fill_ppn   (walk_rsp_ppn),
        .fill_perm  (perm_t'(walk_rsp_perm)),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .hit_ppn    (hit_ppn),
        .hit_perm   (hit_perm),
        .valid_vec  (valid_vec)
    );

    tlb_lru #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_lru (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .valid_vec  (valid_vec),
        .victim_idx (victim_idx)
    );

    tlb_ctrl #(
        .VPN_W (VPN_W),
        .PPN_W (PPN_W),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .flush          (flush),
        .req_valid      (req_valid),
        .req_vpn        (req_vaddr[VA_W-1:PAGE_OFF_W]),
        .req_off        (req_vaddr[PAGE_OFF_W-1:0]),
        .req_acc        (acc_e'(req_acc)),
        .req_ready      (req_ready),
        .hit            (hit),
        .hit_idx        (hit_idx),
        .hit_ppn        (hit_ppn),
        .hit_perm       (hit_perm),
        .victim_idx     (victim_idx),
        .rsp_valid      (rsp_valid),
        .rsp_paddr      (rsp_paddr),
        .rsp_fault      (rsp_fault),
        .walk_req_valid (walk_req_valid),
        .walk_req_vpn   (walk_req_vpn),
        .walk_rsp_valid (walk_rsp_valid),
        .walk_rsp_ppn   (walk_rsp_ppn),
        .walk_rsp_perm  (perm_t'(walk_rsp_perm)),
        .walk_rsp_fault (walk_rsp_fault),
        .fill_en        (fill_en),
        .fill_idx       (fill_idx),
        .fill_vpn       (fill_vpn),
        .touch_en       (touch_en),
        .touch_idx      (touch_idx)
    );

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    localparam int VA_W = VPN_W + 12
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             rsp_valid,
    input logic             walk_req_valid,
    input logic [VPN_W-1:0] walk_req_vpn,
    input logic             walk_rsp_valid
);

    // R4: a request accepted without an answer starts a walk for its page
    p_miss_walks_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !rsp_valid)
        |=> (walk_req_valid && walk_req_vpn == $past(req_vaddr[VA_W-1:12])));

    // R4: an unanswered walk request is held unchanged
    p_walk_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (walk_req_valid && !walk_rsp_valid)
        |=> (walk_req_valid && $stable(walk_req_vpn)));

    // R4: nothing is accepted while a walk is outstanding
    p_busy_no_accept_r4: assert property (@(posedge clk) disable iff (rst)
        walk_req_valid |-> !req_ready);

    // R2 / R3: an answer given on acceptance never leads to a walk
    p_hit_no_walk_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && req_valid && req_ready) |=> !walk_req_valid);

    // R6: the walk ends in the cycle its answer arrives
    p_walk_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (walk_req_valid && walk_rsp_valid) |=> !walk_req_valid);

    // R7: right after a flush nothing can hit
    p_flush_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (flush && !walk_req_valid) |=> !(req_valid && req_ready && rsp_valid));

endmodule

bind tlb_fa tlb_fa_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .flush          (flush),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vaddr      (req_vaddr),
    .rsp_valid      (rsp_valid),
    .walk_req_valid (walk_req_valid),
    .walk_req_vpn   (walk_req_vpn),
    .walk_rsp_valid (walk_rsp_valid)
);

// File: tb/tlb_fa_tb_top.sv
module tlb_fa_tb_top;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        walk_req_valid;
    logic [19:0] walk_req_vpn;
    logic        walk_rsp_valid = 1'b0;
    logic [19:0] walk_rsp_ppn = '0;
    logic [2:0]  walk_rsp_perm = '0;
    logic        walk_rsp_fault = 1'b0;

    int checks = 0;
    int errors = 0;
    logic walk_seen = 1'b0;

    typedef struct {
        logic [31:0] paddr;
        logic        fault;
        logic        walk;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #10ns clk = ~clk;

    tlb_fa #(.ENTRIES(N), .VPN_W(20), .PPN_W(20)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .flush          (flush),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vaddr      (req_vaddr),
        .req_acc        (req_acc),
        .rsp_valid      (rsp_valid),
        .rsp_paddr      (rsp_paddr),
        .rsp_fault      (rsp_fault),
        .walk_req_valid (walk_req_valid),
        .walk_req_vpn   (walk_req_vpn),
        .walk_rsp_valid (walk_rsp_valid),
        .walk_rsp_ppn   (walk_rsp_ppn),
        .walk_rsp_perm  (walk_rsp_perm),
        .walk_rsp_fault (walk_rsp_fault)
    );

    // Page table model used by the walker and by the expectations
    function automatic logic [19:0] pt_ppn(input logic [19:0] v);
        return v ^ 20'h5A5A5;
    endfunction
    function automatic logic [2:0] pt_perm(input logic [19:0] v);
        case (v[19:16])
            4'h1:    return 3'b001;
            4'h2:    return 3'b100;
            default: return 3'b111;
        endcase
    endfunction
    function automatic logic pt_fault(input logic [19:0] v);
        return v[7:0] == 8'hEE;
    endfunction
    function automatic logic allowed(input logic [2:0] p, input logic [1:0] a);
        case (a)
            2'd1:    return p[1];
            2'd2:    return p[2];
            default: return p[0];
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // Driver: push the expected answer, then present the request until taken
    task automatic access(input logic [31:0] va, input logic [1:0] acc,
                          input logic exp_walk, input string tag);
        exp_t e;
        e.paddr = {pt_ppn(va[31:12]), va[11:0]};
        e.fault = pt_fault(va[31:12]) || !allowed(pt_perm(va[31:12]), acc);
        e.walk  = exp_walk;
        e.tag   = tag;
        sb_q.push_back(e);
        @(posedge clk);
        #1ns;
        req_valid = 1'b1;
        req_vaddr = va;
        req_acc   = acc;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #1ns;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && sb_q.size() != 0; i++) @(negedge clk);
        check(sb_q.size() == 0, "R6", $sformatf("pending answers actual %0d expected 0", sb_q.size()));
    endtask

    task automatic flush_pulse(input string tag);
        @(posedge clk);
        #1ns;
        flush = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b0, tag, $sformatf("req_ready during flush actual %0b expected 0", req_ready));
        @(posedge clk);
        #1ns;
        flush = 1'b0;
    endtask

    // Walker model: answers two clocks after it first sees a request
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && walk_req_valid) begin
                logic [19:0] v;
                v = walk_req_vpn;
                check(req_ready == 1'b0, "R4", "req_ready high while walking, expected 0");
                repeat (2) @(posedge clk);
                #1ns;
                walk_rsp_valid = 1'b1;
                walk_rsp_ppn   = pt_ppn(v);
                walk_rsp_perm  = pt_perm(v);
                walk_rsp_fault = pt_fault(v);
                walk_seen      = 1'b1;
                @(posedge clk);
                #1ns;
                walk_rsp_valid = 1'b0;
            end
        end
    end

    // Monitor: compare each answer in the cycle it appears
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected answer, expected none");
                end else begin
                    exp_t e;
                    logic ok;
                    e = sb_q.pop_front();
                    ok = (rsp_fault == e.fault) && (walk_seen == e.walk) &&
                         (e.fault || rsp_paddr == e.paddr);
                    check(ok, e.tag, $sformatf(
                        "paddr/fault/walk actual %h/%0b/%0b expected %h/%0b/%0b",
                        rsp_paddr, rsp_fault, walk_seen, e.paddr, e.fault, e.walk));
                end
                walk_seen = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1ns;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", $sformatf("req_ready actual %0b expected 1", req_ready));
        check(rsp_valid == 1'b0, "R1", $sformatf("rsp_valid actual %0b expected 0", rsp_valid));
        check(walk_req_valid == 1'b0, "R1", $sformatf("walk_req_valid actual %0b expected 0", walk_req_valid));

        // R6 fill, R2 hits with varied offsets and types
        access(32'h0001_2345, 2'd0, 1'b1, "R6");
        access(32'h0001_2FFC, 2'd1, 1'b0, "R2");
        access(32'h0001_2000, 2'd2, 1'b0, "R2");
        // R3 read-only page
        access(32'h1002_0010, 2'd0, 1'b1, "R6");
        access(32'h1002_0020, 2'd1, 1'b0, "R3");
        access(32'h1002_0030, 2'd2, 1'b0, "R3");
        access(32'h1002_0040, 2'd3, 1'b0, "R3");
        // R6 permission check on the fill path, then cached
        access(32'h2003_0100, 2'd1, 1'b1, "R6");
        access(32'h2003_0104, 2'd2, 1'b0, "R6");
        // R5 walk fault installs nothing
        access(32'h000E_E00C, 2'd0, 1'b1, "R5");
        access(32'h000E_E010, 2'd0, 1'b1, "R5");
        drain();

        // R7 flush drops translations
        flush_pulse("R7");
        access(32'h0001_2345, 2'd0, 1'b1, "R7");
        drain();

        // R10 flush while a walk is outstanding
        access(32'h0005_0abc, 2'd0, 1'b1, "R10");
        flush_pulse("R10");
        drain();
        access(32'h0005_0abc, 2'd0, 1'b1, "R10");
        drain();

        // R8 fill every entry, all stay resident
        flush_pulse("R7");
        for (int k = 0; k < N; k++) access({20'h30000 + 20'(k), 12'h008}, 2'd0, 1'b1, "R8");
        for (int k = 0; k < N; k++) access({20'h30000 + 20'(k), 12'h00C}, 2'd1, 1'b0, "R8");
        // R9 oldest is k0
        access(32'h4000_0000, 2'd0, 1'b1, "R9");
        access(32'h3000_1000, 2'd0, 1'b0, "R9");
        access(32'h3000_0000, 2'd0, 1'b1, "R9");
        access(32'h3000_2000, 2'd0, 1'b1, "R9");
        access(32'h3000_4000, 2'd0, 1'b0, "R9");
        access(32'h3000_3000, 2'd0, 1'b1, "R9");
        access(32'h4000_0010, 2'd2, 1'b0, "R9");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule